// File: doc/BRIEF.md
# Per-Channel TDM Output Controller

This block decides, for every time slot of each serial output stream of a time-division switch, what appears on the line. Each output lane owns a control memory with one 16-bit word per channel. The top four bits of a word set the channel's behaviour. In message mode the low byte of the word is sent as it stands. In switched mode the low twelve bits become a read address for an external data store, and the byte that the store returns is sent instead.

Every channel lasts eight clock cycles, one bit per cycle, most significant bit first. During each channel the block fetches the word for the channel that follows, so a word is always settled before its slot begins. A per-channel enable bit gates the line driver for exactly the cycles of that slot. A device-wide condition tristates every lane at once: the external drive-enable input is low and the keep-driving bit is also low. This condition overrides every per-channel setting. The delay-select bit and the test-pattern bit are passed out beside the data, aligned to the slot.

Top module: `tdm_out_ctl`

## Requirements
- R1: With word bit 15 = 1 (message), the word's bits 7:0 are shifted out on `sdo`, MSB first, over the eight cycles of that channel. The same byte is sent again in every frame until the word is rewritten.
- R2: With word bit 15 = 0 (switched), the lane's `dm_rd_addr` carries word bits 11:0 from the third through the last cycle of the preceding channel. The byte sent is the lane's `dm_rd_data` as it stands in that last cycle.
- R3: With no global disable, `sdo_oe` of a lane is 1 in all eight cycles of a channel whose word bit 14 is 1, and 0 in all eight cycles when bit 14 is 0.
- R4: When `ext_drive_en` = 0 and `stby_keep` = 0 in a cycle, every lane's `sdo_oe` is 0 in the next cycle, whatever bit 14 says. Once either input is 1 again, the lanes return to the per-channel setting from the next cycle on, even in the middle of a channel.
- R5: Word bit 13 appears on `dly_sel` and word bit 12 appears on `bert_sel`. Both are held constant over the eight cycles of the channel.
- R6: A write puts `cpu_wdata` at channel `cpu_addr[CH_W-1:0]`. The word is read at the first cycle of the preceding channel. A write made after that read first takes effect in the next frame. No output changes mid-channel because of a write.
- R7: `frame_start` = 1 marks the cycle in which the first bit of channel 0 is on the outputs. Channel k then occupies cycles 8k to 8k+7 after that cycle. The slot count runs freely and wraps after `CH_PER_FRAME` channels.
- R8: During reset all outputs are 0. In the first cycle after reset the slot position is channel 0, bit 0, and channel 0 of that first frame is tristated on every lane.
- R9: The lane is selected by the bits of `cpu_addr` above the channel field. A write changes only that lane's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one serial bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | High in the cycle of channel 0, bit 0 |
| cpu_we | input | 1 | Control-memory write strobe |
| cpu_addr | input | LANE_W+CH_W | {lane, channel} write address |
| cpu_wdata | input | 16 | Control word to store |
| ext_drive_en | input | 1 | Device drive enable, low requests disable |
| stby_keep | input | 1 | Keep-driving bit; 1 blocks the global disable |
| dm_rd_data | input | NUM_OUT*8 | Switched byte per lane from the data store |
| dm_rd_addr | output | NUM_OUT*DM_AW | Source address per lane to the data store |
| sdo | output | NUM_OUT | Serial data per lane |
| sdo_oe | output | NUM_OUT | Driver enable per lane |
| dly_sel | output | NUM_OUT | Delay-mode select for the current slot |
| bert_sel | output | NUM_OUT | Test-pattern select for the current slot |

## Verification
The assertions watch, on every cycle, the properties that follow from the timing alone. The global disable must silence every lane one cycle later. The enable and the sideband bits must not move inside a channel. The data-store address must hold from the third to the last bit of a slot. Reset must leave the lines quiet. Only the bench scenarios can show which byte lands in which slot. That covers message versus switched content, repetition across frames, the frame in which a late write first appears, the tristated first slot after reset, and the fact that one lane's write leaves the other lane alone.

// File: rtl/tdm_oc_pkg.sv
`timescale 1ns/1ps
package tdm_oc_pkg;
  localparam int CW        = 16;
  localparam int SLOT_BITS = 8;
  localparam int BIT_W     = $clog2(SLOT_BITS);
  localparam int MSG_BIT   = 15;
  localparam int OE_BIT    = 14;
  localparam int DLY_BIT   = 13;
  localparam int BERT_BIT  = 12;
  localparam int SRC_MAX_W = 12;

  typedef struct packed {
    logic msg;
    logic oe;
    logic dly;
    logic bert;
  } slot_ctl_t;

  function automatic slot_ctl_t ctl_of(input logic [CW-1:0] w);
    slot_ctl_t c;
    c.msg  = w[MSG_BIT];
    c.oe   = w[OE_BIT];
    c.dly  = w[DLY_BIT];
    c.bert = w[BERT_BIT];
    return c;
  endfunction
endpackage

// File: rtl/tdm_slot_timer.sv
`timescale 1ns/1ps
module tdm_slot_timer import tdm_oc_pkg::*; #(
  parameter int CH_PER_FRAME = 8,
  localparam int CH_W = $clog2(CH_PER_FRAME)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  output logic [BIT_W-1:0] cur_bit,
  output logic [CH_W-1:0]  fetch_ch,
  output logic             fetch_stb,
  output logic             capt_stb,
  output logic             last_stb
);
  localparam logic [CH_W-1:0]  LAST_CH  = CH_W'(CH_PER_FRAME - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SLOT_BITS - 1);

  logic [CH_W-1:0]  ch_q, ch_now;
  logic [BIT_W-1:0] bit_q, bit_now;

  // position of the present cycle, derived from the previous one
  always_comb begin
    if (frame_start) begin
      ch_now  = '0;
      bit_now = '0;
    end else if (bit_q == LAST_BIT) begin
      bit_now = '0;
      ch_now  = (ch_q == LAST_CH) ? '0 : ch_q + 1'b1;
    end else begin
      bit_now = bit_q + 1'b1;
      ch_now  = ch_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_q  <= LAST_CH;
      bit_q <= LAST_BIT;
    end else begin
      ch_q  <= ch_now;
      bit_q <= bit_now;
    end
  end

  assign cur_bit   = bit_now;
  assign fetch_ch  = (ch_now == LAST_CH) ? '0 : ch_now + 1'b1;
  assign fetch_stb = (bit_now == '0);
  assign capt_stb  = (bit_now == BIT_W'(1));
  assign last_stb  = (bit_now == LAST_BIT);
endmodule

// File: rtl/tdm_cm_ram.sv
`timescale 1ns/1ps
module tdm_cm_ram #(
  parameter int DEPTH = 8,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tdm_out_lane.sv
`timescale 1ns/1ps
module tdm_out_lane import tdm_oc_pkg::*; #(
  parameter int CH_PER_FRAME = 8,
  parameter int DM_AW        = 12,
  localparam int CH_W = $clog2(CH_PER_FRAME)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CH_W-1:0]  fetch_ch,
  input  logic             capt_stb,
  input  logic             last_stb,
  input  logic             global_off,
  input  logic             wr_en,
  input  logic [CH_W-1:0]  wr_ch,
  input  logic [CW-1:0]    wr_data,
  input  logic [7:0]       sw_byte,
  output logic [DM_AW-1:0] src_addr,
  output logic             ser_out,
  output logic             ser_oe,
  output logic             dly_out,
  output logic             bert_out
);
  logic [CW-1:0]    cm_word;
  slot_ctl_t        nxt_ctl;
  logic [7:0]       nxt_byte;
  logic [DM_AW-1:0] src_q;
  logic [7:0]       sh_q;
  logic             slot_oe_q, oe_q, dly_q, bert_q;

  tdm_cm_ram #(.DEPTH(CH_PER_FRAME), .W(CW)) u_cm (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_ch),
    .wdata (wr_data),
    .raddr (fetch_ch),
    .rdata (cm_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      nxt_ctl   <= '0;
      nxt_byte  <= '0;
      src_q     <= '0;
      sh_q      <= '0;
      slot_oe_q <= 1'b0;
      oe_q      <= 1'b0;
      dly_q     <= 1'b0;
      bert_q    <= 1'b0;
    end else begin
      // word of the next channel is latched once per channel
      if (capt_stb) begin
        nxt_ctl  <= ctl_of(cm_word);
        nxt_byte <= cm_word[7:0];
        src_q    <= cm_word[DM_AW-1:0];
      end
      if (last_stb) begin
        sh_q      <= nxt_ctl.msg ? nxt_byte : sw_byte;
        slot_oe_q <= nxt_ctl.oe;
        dly_q     <= nxt_ctl.dly;
        bert_q    <= nxt_ctl.bert;
      end else begin
        sh_q <= {sh_q[6:0], 1'b0};
      end
      oe_q <= (last_stb ? nxt_ctl.oe : slot_oe_q) & ~global_off;
    end
  end

  assign src_addr = src_q;
  assign ser_out  = sh_q[7];
  assign ser_oe   = oe_q;
  assign dly_out  = dly_q;
  assign bert_out = bert_q;
endmodule

// File: rtl/tdm_out_ctl.sv
`timescale 1ns/1ps
module tdm_out_ctl import tdm_oc_pkg::*; #(
  parameter int NUM_OUT      = 2,
  parameter int CH_PER_FRAME = 8,
  parameter int DM_AW        = 12,
  localparam int CH_W   = $clog2(CH_PER_FRAME),
  localparam int LANE_W = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1,
  localparam int CA_W   = CH_W + LANE_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     frame_start,
  input  logic                     cpu_we,
  input  logic [CA_W-1:0]          cpu_addr,
  input  logic [CW-1:0]            cpu_wdata,
  input  logic                     ext_drive_en,
  input  logic                     stby_keep,
  input  logic [NUM_OUT*8-1:0]     dm_rd_data,
  output logic [NUM_OUT*DM_AW-1:0] dm_rd_addr,
  output logic [NUM_OUT-1:0]       sdo,
  output logic [NUM_OUT-1:0]       sdo_oe,
  output logic [NUM_OUT-1:0]       dly_sel,
  output logic [NUM_OUT-1:0]       bert_sel
);
  logic [BIT_W-1:0] cur_bit;
  logic [CH_W-1:0]  fetch_ch;
  logic             fetch_stb, capt_stb, last_stb;
  logic             glob_off;

  assign glob_off = ~ext_drive_en & ~stby_keep;

  tdm_slot_timer #(.CH_PER_FRAME(CH_PER_FRAME)) u_timer (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .cur_bit     (cur_bit),
    .fetch_ch    (fetch_ch),
    .fetch_stb   (fetch_stb),
    .capt_stb    (capt_stb),
    .last_stb    (last_stb)
  );

  for (genvar l = 0; l < NUM_OUT; l++) begin : g_lane
    logic lane_we;
    assign lane_we = cpu_we && (cpu_addr[CA_W-1:CH_W] == LANE_W'(l));

    tdm_out_lane #(.CH_PER_FRAME(CH_PER_FRAME), .DM_AW(DM_AW)) u_lane (
      .clk        (clk),
      .rst        (rst),
      .fetch_ch   (fetch_ch),
      .capt_stb   (capt_stb),
      .last_stb   (last_stb),
      .global_off (glob_off),
      .wr_en      (lane_we),
      .wr_ch      (cpu_addr[CH_W-1:0]),
      .wr_data    (cpu_wdata),
      .sw_byte    (dm_rd_data[l*8 +: 8]),
      .src_addr   (dm_rd_addr[l*DM_AW +: DM_AW]),
      .ser_out    (sdo[l]),
      .ser_oe     (sdo_oe[l]),
      .dly_out    (dly_sel[l]),
      .bert_out   (bert_sel[l])
    );
  end

  // fetch strobe marks the read cycle of the control memory; kept visible for checking
  logic fetch_seen;
  assign fetch_seen = fetch_stb;
endmodule

// File: rtl/tdm_out_ctl_chk.sv
`timescale 1ns/1ps
module tdm_out_ctl_chk import tdm_oc_pkg::*; #(
  parameter int NUM_OUT = 2,
  parameter int DM_AW   = 12
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     global_off,
  input logic                     fetch_seen,
  input logic [BIT_W-1:0]         bit_idx,
  input logic [NUM_OUT-1:0]       sdo_oe,
  input logic [NUM_OUT-1:0]       dly_sel,
  input logic [NUM_OUT-1:0]       bert_sel,
  input logic [NUM_OUT*DM_AW-1:0] dm_rd_addr
);
  logic g1, g2;
  always_ff @(posedge clk) begin
    if (rst) begin
      g1 <= 1'b1;
      g2 <= 1'b1;
    end else begin
      g1 <= global_off;
      g2 <= g1;
    end
  end

  assert_global_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    $past(global_off) |-> (sdo_oe == '0));

  assert_oe_slot_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (bit_idx != '0 && !g1 && !g2) |-> $stable(sdo_oe));

  assert_side_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (bit_idx != '0) |-> ($stable(dly_sel) && $stable(bert_sel)));

  assert_src_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (bit_idx >= BIT_W'(3)) |-> $stable(dm_rd_addr));

  assert_reset_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sdo_oe == '0 && dly_sel == '0 && bert_sel == '0 && fetch_seen));
endmodule

bind tdm_out_ctl tdm_out_ctl_chk #(.NUM_OUT(NUM_OUT), .DM_AW(DM_AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .global_off (glob_off),
  .fetch_seen (fetch_seen),
  .bit_idx    (cur_bit),
  .sdo_oe     (sdo_oe),
  .dly_sel    (dly_sel),
  .bert_sel   (bert_sel),
  .dm_rd_addr (dm_rd_addr)
);

// File: tb/tdm_out_ctl_bench.sv
`timescale 1ns/1ps
module tdm_out_ctl_bench;
  localparam int NO = 2;
  localparam int CH = 8;
  localparam int AW = 12;
  localparam int FRAME = CH * 8;

  // stimulus vectors: control word per {lane, channel}
  localparam logic [15:0] TBL [NO*CH] = '{
    16'hC0A5, 16'h4012, 16'h80FF, 16'hE03C, 16'h5081, 16'h0000, 16'hF000, 16'h40FE,
    16'h4007, 16'hC080, 16'h6333, 16'hC001, 16'h9055, 16'hC0FF, 16'h7120, 16'hC07E
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic            rst = 1'b1, frame_start = 1'b0, cpu_we = 1'b0;
  logic [3:0]      cpu_addr = '0;
  logic [15:0]     cpu_wdata = '0;
  logic            ext_drive_en = 1'b1, stby_keep = 1'b0;
  logic [NO*8-1:0] dm_rd_data = '0;
  logic [NO*AW-1:0] dm_rd_addr;
  logic [NO-1:0]   sdo, sdo_oe, dly_sel, bert_sel;

  tdm_out_ctl #(.NUM_OUT(NO), .CH_PER_FRAME(CH), .DM_AW(AW)) u_tdm_out_ctl (
    .clk(clk), .rst(rst), .frame_start(frame_start), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .ext_drive_en(ext_drive_en),
    .stby_keep(stby_keep), .dm_rd_data(dm_rd_data), .dm_rd_addr(dm_rd_addr),
    .sdo(sdo), .sdo_oe(sdo_oe), .dly_sel(dly_sel), .bert_sel(bert_sel)
  );

  int cyc;
  always @(posedge clk) if (rst) cyc <= 0; else cyc <= cyc + 1;

  int nerr = 0, nchk = 0;
  logic [15:0] words [NO][CH];
  logic [7:0]  cb  [NO][CH];
  int          coe [NO][CH];
  logic        cd  [NO][CH], cbt [NO][CH], cvar [NO][CH];

  function automatic logic [7:0] dmf(input logic [AW-1:0] a);
    return 8'((a * 29) + (a >> 8)) ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic sample();
    frame_start = !rst && ((cyc % FRAME) == 0);
    for (int l = 0; l < NO; l++) dm_rd_data[l*8 +: 8] = dmf(dm_rd_addr[l*AW +: AW]);
    if (!rst) begin
      int b, c;
      b = cyc % 8;
      c = (cyc / 8) % CH;
      for (int l = 0; l < NO; l++) begin
        if (b == 0) begin
          coe[l][c] = 0; cd[l][c] = dly_sel[l]; cbt[l][c] = bert_sel[l]; cvar[l][c] = 1'b0;
        end
        cb[l][c][7-b] = sdo[l];
        coe[l][c] += int'(sdo_oe[l]);
        if (dly_sel[l] != cd[l][c] || bert_sel[l] != cbt[l][c]) cvar[l][c] = 1'b1;
      end
    end
  endtask

  task automatic tick();
    @(negedge clk);
    sample();
  endtask

  task automatic to_frame_end();
    do tick(); while ((cyc % FRAME) != FRAME - 1);
  endtask

  task automatic to_pos(input int p);
    do tick(); while ((cyc % FRAME) != p);
  endtask

  task automatic cpu_write(input int l, input int c, input logic [15:0] w);
    cpu_we = 1'b1; cpu_addr = {1'(l), 3'(c)}; cpu_wdata = w;
    tick();
    cpu_we = 1'b0;
  endtask

  task automatic check_slot(input int l, input int c, input logic [15:0] w,
                            input bit gl, input string req);
    int eoe;
    logic [7:0] eb;
    eoe = (gl || !w[14]) ? 0 : 8;
    eb  = w[15] ? w[7:0] : dmf(w[11:0]);
    chk(coe[l][c] == eoe, req, $sformatf("oe cycles lane%0d ch%0d", l, c), coe[l][c], eoe);
    if (eoe == 8)
      chk(cb[l][c] == eb, req, $sformatf("byte lane%0d ch%0d", l, c), cb[l][c], eb);
    chk({cd[l][c], cbt[l][c], cvar[l][c]} == {w[13], w[12], 1'b0}, "R5",
        $sformatf("sideband lane%0d ch%0d", l, c), {cd[l][c], cbt[l][c], cvar[l][c]},
        {w[13], w[12], 1'b0});
  endtask

  task automatic check_all(input bit gl, input string req);
    for (int l = 0; l < NO; l++)
      for (int c = 0; c < CH; c++) check_slot(l, c, words[l][c], gl, req);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    // R8: outputs quiet in reset; the table is loaded meanwhile
    repeat (3) tick();
    chk(sdo_oe == '0 && sdo == '0 && dly_sel == '0 && bert_sel == '0, "R8",
        "reset outputs", {sdo_oe, sdo, dly_sel, bert_sel}, 0);
    for (int i = 0; i < NO * CH; i++) begin
      words[i / CH][i % CH] = TBL[i];
      cpu_write(i / CH, i % CH, TBL[i]);
    end
    chk(sdo_oe == '0, "R8", "oe after writes in reset", sdo_oe, 0);
    @(negedge clk);
    rst = 1'b0;
    sample();
    to_frame_end();
    // R8: channel 0 of the first frame is tristated on both lanes
    for (int l = 0; l < NO; l++)
      chk(coe[l][0] == 0, "R8", $sformatf("first slot lane%0d", l), coe[l][0], 0);
    for (int l = 0; l < NO; l++)
      for (int c = 1; c < CH; c++) check_slot(l, c, words[l][c], 1'b0, "R7");
    // R1, R2, R3, R7: full frame
    to_frame_end();
    check_all(1'b0, "R1/R2/R3 R7");
    // R1: message byte repeats in the next frame
    to_frame_end();
    check_slot(0, 0, words[0][0], 1'b0, "R1");
    check_slot(1, 1, words[1][1], 1'b0, "R1");
    // R4: global disable for a whole frame
    ext_drive_en = 1'b0; stby_keep = 1'b0;
    to_frame_end();
    check_all(1'b1, "R4");
    // R4: keep bit blocks the disable
    stby_keep = 1'b1;
    to_frame_end();
    check_all(1'b0, "R4");
    // R4: drive enable high, keep bit low
    ext_drive_en = 1'b1; stby_keep = 1'b0;
    to_frame_end();
    check_all(1'b0, "R4");
    // R4 then R3: mid-channel drop and recovery on lane0 ch1
    to_pos(11);
    chk(sdo_oe[0] == 1'b1, "R3", "oe before drop", sdo_oe[0], 1);
    ext_drive_en = 1'b0;
    tick();
    chk(sdo_oe == '0, "R4", "oe one cycle after disable", sdo_oe, 0);
    ext_drive_en = 1'b1;
    tick();
    chk(sdo_oe[0] == 1'b1, "R3", "oe resumes mid-channel", sdo_oe[0], 1);
    // R6: writes after the fetch of ch4 and during ch3 apply next frame
    to_pos(27);
    cpu_write(0, 4, 16'hC077);
    cpu_write(0, 3, 16'hC05A);
    to_frame_end();
    check_slot(0, 3, words[0][3], 1'b0, "R6");
    check_slot(0, 4, words[0][4], 1'b0, "R6");
    words[0][3] = 16'hC05A; words[0][4] = 16'hC077;
    to_frame_end();
    check_slot(0, 3, words[0][3], 1'b0, "R6");
    check_slot(0, 4, words[0][4], 1'b0, "R6");
    // R9: lane1 write leaves lane0 alone
    cpu_write(1, 5, 16'hC099);
    words[1][5] = 16'hC099;
    to_frame_end();
    to_frame_end();
    check_slot(1, 5, words[1][5], 1'b0, "R9");
    check_slot(0, 5, words[0][5], 1'b0, "R9");
    // R2: switched slot with a fresh source address
    cpu_write(1, 0, 16'h4ABC);
    words[1][0] = 16'h4ABC;
    to_frame_end();
    to_frame_end();
    check_slot(1, 0, words[1][0], 1'b0, "R2");
    finish_run();
  end
endmodule